// File: doc/BRIEF.md
# Out-of-Order Sequence Tracker

This block follows packet arrivals on several connections and keeps, for each connection, a delivery pointer: the next sequence number that can be released in order. An arrival names a connection and a 24-bit sequence number. Arrivals that land ahead of the pointer are recorded, and the pointer moves forward only across an unbroken run of recorded numbers. Packets are therefore released in sequence order even when the network reorders them.

Each connection has a small private circular bitmap covering the first `CW` numbers past its pointer. Arrivals further ahead are recorded in bitmap blocks taken on demand from a pool shared by all connections. Each block covers `BLKW` numbers aligned to a multiple of `BLKW`. A block goes back to the pool once its owner's pointer has moved past its whole range. Every arrival gets a one-cycle-later result that marks it as accepted, duplicate, or dropped. Payload storage and retransmission are handled elsewhere.

Top module: `ooo_seq_tracker`

## Requirements
- R1: After reset, every connection's delivery pointer is 0, `res_valid` is 0, and both flags are 0.
- R2: Each cycle with `arr_valid` high gives exactly one result on the next cycle. `res_valid` is high in that cycle and in no other. `res_dup` and `res_drop` are never high together, and both are 0 when `res_valid` is 0.
- R3: An arrival equal to the delivery pointer, when that number is not already recorded, advances the pointer by one at the same clock edge that registers the result.
- R4: An arrival ahead of the pointer is recorded without moving the pointer. When the pointer reaches a recorded number, the pointer steps past it on the next clock edge. Over a contiguous run it moves one number per clock, and it never moves more than one per clock.
- R5: An arrival whose modular offset from the pointer (sequence minus pointer, modulo 2^24) has bit 23 set lies behind the pointer. It is flagged as a duplicate and changes nothing.
- R6: An arrival whose number is already recorded, in the circular bitmap or in a pool block, is flagged as a duplicate and changes nothing.
- R7: An arrival with offset of at least `CW` but below `CW + NBLK*BLKW` is recorded in a pool block. The block is owned by the connection and covers the aligned `BLKW`-number range around the arrival. Later arrivals in that range on the same connection reuse the block.
- R8: An arrival with offset of `CW + NBLK*BLKW` or more (bit 23 clear) is flagged as dropped and changes nothing.
- R9: An arrival that needs a new block while all `NBLK` blocks are in use is flagged as dropped and changes nothing.
- R10: A block returns to the pool once its owner's pointer is at least `BLKW` past the block's first number. After that, a new allocation can succeed.
- R11: All offsets and pointer increments wrap modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | An arrival is presented this cycle |
| arr_conn | input | CNW | Connection of the arrival |
| arr_seq | input | SEQW | Sequence number of the arrival |
| exp_seq | output | NCONN*SEQW | Delivery pointers; connection c occupies bits c*SEQW upward |
| res_valid | output | 1 | Result of the previous cycle's arrival |
| res_dup | output | 1 | That arrival was behind the pointer or already recorded |
| res_drop | output | 1 | That arrival was too far ahead, or no block was free |

## Verification
The hardest case to reach is pool exhaustion followed by block return. All blocks must be held at once by different connections and ranges, and then one connection's pointer must be driven past the end of its block. The bench first sends far arrivals on two connections until the pool is full, and shows that a new range is dropped while an existing block still accepts arrivals. It then fills the gap below one block number by number until the pointer drains through it, and repeats the rejected arrival, which is now accepted.

// File: rtl/ooo_seq_tracker.sv
module ooo_seq_tracker #(
  parameter int NCONN = 4,
  parameter int SEQW  = 24,
  parameter int CW    = 16,
  parameter int BLKW  = 16,
  parameter int NBLK  = 4,
  localparam int CNW  = (NCONN > 1) ? $clog2(NCONN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arr_valid,
  input  logic [CNW-1:0]         arr_conn,
  input  logic [SEQW-1:0]        arr_seq,
  output logic [NCONN*SEQW-1:0]  exp_seq,
  output logic                   res_valid,
  output logic                   res_dup,
  output logic                   res_drop
);
  localparam int CWL = $clog2(CW);
  localparam int BW  = $clog2(BLKW);
  localparam int PW  = SEQW - BW;
  localparam int FAR = CW + NBLK * BLKW;

  logic [SEQW-1:0] ptr  [NCONN];
  logic [CW-1:0]   circ [NCONN];
  logic [CW-1:0]   circ_nx [NCONN];
  logic [NCONN-1:0] hd_set, adv;

  logic [NBLK-1:0] blk_use, blk_free_now, a_hit, a_free_oh;
  logic [CNW-1:0]  blk_conn [NBLK];
  logic [PW-1:0]   blk_base [NBLK];
  logic [BLKW-1:0] blk_bits [NBLK];

  logic [SEQW-1:0] a_off;
  logic a_behind, a_now, a_circ, a_far, a_lin, a_blkset, a_dup, a_drop, a_ok, a_alloc;

  genvar gc;
  generate
    for (gc = 0; gc < NCONN; gc++) begin : g_out
      assign exp_seq[gc*SEQW +: SEQW] = ptr[gc];
    end
  endgenerate

  assign a_off    = arr_seq - ptr[arr_conn];
  assign a_behind = a_off[SEQW-1];
  assign a_now    = (a_off == '0);
  assign a_far    = !a_behind && (a_off >= SEQW'(FAR));
  assign a_circ   = !a_behind && !a_now && (a_off < SEQW'(CW));
  assign a_lin    = !a_behind && !a_far && (a_off >= SEQW'(CW));

  always_comb begin
    a_blkset  = 1'b0;
    a_free_oh = '0;
    for (int b = 0; b < NBLK; b++) begin
      a_hit[b] = blk_use[b] && (blk_conn[b] == arr_conn) && (blk_base[b] == arr_seq[SEQW-1:BW]);
      if (a_hit[b] && blk_bits[b][arr_seq[BW-1:0]]) a_blkset = 1'b1;
      if (!blk_use[b] && (a_free_oh == '0)) a_free_oh[b] = 1'b1;
    end
  end

  assign a_dup   = a_behind || (a_circ && circ[arr_conn][arr_seq[CWL-1:0]])
                 || (!a_far && a_blkset) || (a_now && hd_set[arr_conn]);
  assign a_alloc = a_lin && (a_hit == '0);
  assign a_drop  = !a_dup && (a_far || (a_alloc && (a_free_oh == '0)));
  assign a_ok    = arr_valid && !a_dup && !a_drop;

  always_comb begin
    for (int c = 0; c < NCONN; c++) begin
      hd_set[c] = circ[c][ptr[c][CWL-1:0]];
      for (int b = 0; b < NBLK; b++)
        if (blk_use[b] && (blk_conn[b] == CNW'(c)) && (blk_base[b] == ptr[c][SEQW-1:BW])
            && blk_bits[b][ptr[c][BW-1:0]])
          hd_set[c] = 1'b1;
      adv[c] = hd_set[c] || (a_ok && a_now && (arr_conn == CNW'(c)));
      circ_nx[c] = circ[c];
      if (hd_set[c]) circ_nx[c][ptr[c][CWL-1:0]] = 1'b0;
      if (a_ok && a_circ && (arr_conn == CNW'(c))) circ_nx[c][arr_seq[CWL-1:0]] = 1'b1;
    end
  end

  always_comb begin
    for (int b = 0; b < NBLK; b++) begin
      logic [SEQW-1:0] rel;
      rel = ptr[blk_conn[b]] - {blk_base[b], {BW{1'b0}}};
      blk_free_now[b] = blk_use[b] && !rel[SEQW-1] && (rel >= SEQW'(BLKW));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_dup   <= 1'b0;
      res_drop  <= 1'b0;
      blk_use   <= '0;
      for (int c = 0; c < NCONN; c++) begin
        ptr[c]  <= '0;
        circ[c] <= '0;
      end
      for (int b = 0; b < NBLK; b++) begin
        blk_conn[b] <= '0;
        blk_base[b] <= '0;
        blk_bits[b] <= '0;
      end
    end else begin
      res_valid <= arr_valid;
      res_dup   <= arr_valid && a_dup;
      res_drop  <= arr_valid && a_drop;
      for (int c = 0; c < NCONN; c++) begin
        circ[c] <= circ_nx[c];
        if (adv[c]) ptr[c] <= ptr[c] + 1'b1;
      end
      for (int b = 0; b < NBLK; b++) begin
        if (blk_free_now[b]) blk_use[b] <= 1'b0;
        if (a_ok && a_lin && a_hit[b]) begin
          blk_bits[b][arr_seq[BW-1:0]] <= 1'b1;
        end else if (a_ok && a_alloc && a_free_oh[b]) begin
          blk_use[b]  <= 1'b1;
          blk_conn[b] <= arr_conn;
          blk_base[b] <= arr_seq[SEQW-1:BW];
          blk_bits[b] <= BLKW'(1) << arr_seq[BW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/ooo_seq_tracker_chk.sv
module ooo_seq_tracker_chk #(
  parameter int NCONN = 4,
  parameter int SEQW  = 24,
  parameter int CW    = 16,
  parameter int BLKW  = 16,
  parameter int NBLK  = 4,
  localparam int CNW  = (NCONN > 1) ? $clog2(NCONN) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  arr_valid,
  input logic [CNW-1:0]        arr_conn,
  input logic [SEQW-1:0]       arr_seq,
  input logic [NCONN*SEQW-1:0] exp_seq,
  input logic                  res_valid,
  input logic                  res_dup,
  input logic                  res_drop
);
  localparam int FAR = CW + NBLK * BLKW;
  logic [SEQW-1:0] off;
  assign off = arr_seq - exp_seq[arr_conn*SEQW +: SEQW];

  AST_ONE_RESULT:  assert property (@(posedge clk) disable iff (!rst_n) arr_valid |=> res_valid); // R2
  AST_NO_PHANTOM:  assert property (@(posedge clk) disable iff (!rst_n) !arr_valid |=> !res_valid); // R2
  AST_FLAGS_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !(res_dup && res_drop)); // R2
  AST_FLAGS_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> (!res_dup && !res_drop)); // R2
  AST_BEHIND_DUP:  assert property (@(posedge clk) disable iff (!rst_n) (arr_valid && off[SEQW-1]) |=> res_dup); // R5
  AST_FAR_DROP:    assert property (@(posedge clk) disable iff (!rst_n)
                     (arr_valid && !off[SEQW-1] && off >= SEQW'(FAR)) |=> res_drop); // R8

  genvar gc;
  generate
    for (gc = 0; gc < NCONN; gc++) begin : g_step
      AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_seq[gc*SEQW +: SEQW] - $past(exp_seq[gc*SEQW +: SEQW])) <= SEQW'(1)); // R4
    end
  endgenerate
endmodule

bind ooo_seq_tracker ooo_seq_tracker_chk #(
  .NCONN(NCONN), .SEQW(SEQW), .CW(CW), .BLKW(BLKW), .NBLK(NBLK)
) u_chk (.*);

// File: tb/sim_ooo_seq_tracker.sv
`timescale 1ns/1ps
module sim_ooo_seq_tracker;
  localparam int NCONN = 4, SEQW = 24, CW = 16, BLKW = 16, NBLK = 4;
  localparam int FAR = CW + NBLK * BLKW;

  logic clk = 1'b0, rst_n = 1'b0, arr_valid = 1'b0;
  logic [1:0] arr_conn = '0;
  logic [SEQW-1:0] arr_seq = '0;
  logic [NCONN*SEQW-1:0] exp_seq;
  logic res_valid, res_dup, res_drop;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ooo_seq_tracker u0 (.clk, .rst_n, .arr_valid, .arr_conn, .arr_seq,
                      .exp_seq, .res_valid, .res_dup, .res_drop);

  task automatic check(input string req, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ptr_of(input int c);
    return int'(exp_seq[c*SEQW +: SEQW]);
  endfunction

  task automatic arrive(input int c, input int s, output logic d, output logic p);
    arr_valid = 1'b1; arr_conn = 2'(c); arr_seq = SEQW'(s);
    @(posedge clk); @(negedge clk);
    arr_valid = 1'b0;
    d = res_dup; p = res_drop;
  endtask

  task automatic expect_arr(input string req, input int c, input int s, input int d_e, input int p_e);
    logic d, p;
    arrive(c, s, d, p);
    check({req, " valid"}, int'(res_valid), 1);
    check({req, " dup"}, int'(d), d_e);
    check({req, " drop"}, int'(p), p_e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCONN; c++) check("R1 ptr", ptr_of(c), 0);
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 flags", int'(res_dup | res_drop), 0);
  endtask

  task automatic t_inorder;
    for (int s = 0; s < 3; s++) begin
      expect_arr("R3", 0, s, 0, 0);
      check("R3 step", ptr_of(0), s + 1);
    end
    idle(1);
    check("R2 idle", int'(res_valid), 0);
  endtask

  task automatic t_reorder;
    expect_arr("R4", 1, 2, 0, 0);
    expect_arr("R4", 1, 3, 0, 0);
    expect_arr("R4", 1, 1, 0, 0);
    check("R4 held", ptr_of(1), 0);
    expect_arr("R4", 1, 0, 0, 0);
    check("R4 first", ptr_of(1), 1);
    idle(1);
    check("R4 one per clock", ptr_of(1), 2);
    idle(4);
    check("R4 drained", ptr_of(1), 4);
  endtask

  task automatic t_dup;
    expect_arr("R5 behind", 1, 2, 1, 0);
    check("R5 ptr", ptr_of(1), 4);
    expect_arr("R6", 2, 5, 0, 0);
    expect_arr("R6 again", 2, 5, 1, 0);
    check("R6 ptr", ptr_of(2), 0);
  endtask

  task automatic t_linear;
    expect_arr("R7 alloc", 2, 20, 0, 0);
    expect_arr("R7 block dup", 2, 20, 1, 0);
    for (int s = 0; s < 5; s++) expect_arr("R7 fill", 2, s, 0, 0);
    for (int s = 6; s < 20; s++) expect_arr("R7 fill", 2, s, 0, 0);
    idle(4);
    check("R7 through block", ptr_of(2), 21);
  endtask

  task automatic t_far_and_pool;
    expect_arr("R8 far", 3, FAR, 0, 1);
    expect_arr("R8 edge", 3, FAR - 1, 0, 0);
    expect_arr("R9 fill", 3, 20, 0, 0);
    expect_arr("R9 fill", 3, 40, 0, 0);
    expect_arr("R9 empty", 0, 30, 0, 1);
    expect_arr("R9 reuse", 3, 41, 0, 0);
    expect_arr("R9 reuse", 3, 30, 0, 0);
    check("R9 ptr", ptr_of(3), 0);
  endtask

  task automatic t_return;
    for (int s = 21; s < 32; s++) expect_arr("R10 drain", 2, s, 0, 0);
    idle(2);
    check("R10 ptr", ptr_of(2), 32);
    expect_arr("R10 realloc", 0, 30, 0, 0);
    expect_arr("R10 realloc dup", 0, 30, 1, 0);
  endtask

  task automatic t_wrap;
    expect_arr("R11 below zero", 1, 24'hFFFFFF, 1, 0);
    expect_arr("R11 half", 1, 24'h800004, 1, 0);
    check("R11 ptr", ptr_of(1), 4);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_inorder();
    t_reorder();
    t_dup();
    t_linear();
    t_far_and_pool();
    t_return();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule